// File: doc/BRIEF.md
# Indexed Colour Pixel Stage with Hardware Cursor

This block sits between a framebuffer fetch engine and a video output. Each clock it can take one 8-bit pixel index with its raster coordinates. It looks the index up in a 256-entry colour table and produces a 24-bit RGB value two clocks later. A 64x64 cursor with two bits per pixel can be laid over the picture. Each cursor code either lets the palette colour through or picks one of three cursor colours. A blanking control forces every output pixel to black.

A register block loads the tables through a single write port. It also drives the cursor position and the two control bits as static inputs. The pipeline has no state machine. Two pipeline stages run on every clock: LOOKUP reads the palette and decodes the cursor code, and MERGE chooses the final colour. A valid flag travels through both stages with the data.

Top module: `pp_pixel_pipe`

## Requirements
- R1: The RGB result for a pixel appears exactly two clocks after the pixel is presented. `out_valid` repeats `pix_valid` with the same two-clock delay.
- R2: Outside the cursor window, `out_rgb` equals the colour table entry selected by `pix_idx`. An entry holds red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R3: When `wr_en` is high, `wr_target` selects the store being written. Code 0 is the colour table, which uses `wr_addr[7:0]` and `wr_data[23:0]`. Code 1 is the cursor colour table, which uses `wr_addr[1:0]` and `wr_data[23:0]`. Code 2 is the cursor pattern, which uses `wr_addr[8:0]` and `wr_data[15:0]`.
- R4: A pixel lies inside the cursor window when `cur_x <= pix_x < cur_x+64` and `cur_y <= pix_y < cur_y+64`.
- R5: Inside the window, take the column offset dx and the row offset dy from the cursor corner. The pixel reads pattern word dy*8 + dx/8. Its 2-bit code sits at bits (dx mod 8)*2+1 : (dx mod 8)*2 of that word.
- R6: Cursor code 0 is transparent and shows the colour table entry. Codes 1, 2 and 3 show cursor colours 0, 1 and 2.
- R7: While `cur_off` is high, no pixel is treated as lying inside the cursor window.
- R8: A pixel presented while `force_blank` is high produces `out_rgb` = 0.
- R9: Reset clears every colour table entry, every cursor colour and every pattern word to zero, and drives `out_valid` and `out_rgb` low.
- R10: A pixel that reads a colour table entry in the same clock as that entry is written receives the old contents. The next read receives the new contents.
- R11: Writes with `wr_target` = 3 have no effect, and neither do cursor colour writes with `wr_addr[1:0]` = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | A pixel is presented this clock |
| pix_idx | input | 8 | Colour table index of the pixel |
| pix_x | input | 12 | Pixel column |
| pix_y | input | 12 | Pixel row |
| cur_x | input | 12 | Cursor left column |
| cur_y | input | 12 | Cursor top row |
| cur_off | input | 1 | Cursor disabled |
| force_blank | input | 1 | Force black output |
| wr_en | input | 1 | Table write strobe |
| wr_target | input | 2 | Store selected for the write |
| wr_addr | input | 9 | Entry or word address |
| wr_data | input | 24 | Write data |
| out_valid | output | 1 | `out_rgb` holds a pixel |
| out_rgb | output | 24 | Output colour |

## Verification
The bench probes the four edges of the cursor window: the first and last columns and rows inside it, and the pixels just outside it. A window comparison that is off by one would paint a cursor colour onto palette pixels or drop one, and a swapped row/column term in the word address would fetch codes from the wrong word. Codes at bit groups other than the lowest catch a wrong shift. A same-clock palette write and read shows whether a bypass leaks new data into the stream. Out-of-range and unused-target writes are then read back through the pixel path to show that they corrupted nothing.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int IDX_W   = 8;
    localparam int COORD_W = 12;
    localparam int CH_W    = 8;
    localparam int RGB_W   = 3 * CH_W;
    localparam int CUR_DIM = 64;
    localparam int CP_N    = 3;

    typedef enum logic [1:0] {
        WT_PALETTE = 2'd0,
        WT_CURPAL  = 2'd1,
        WT_PATTERN = 2'd2,
        WT_NONE    = 2'd3
    } wr_target_e;
endpackage

// File: rtl/pp_palette_ram.sv
module pp_palette_ram #(
    parameter int IDX_W = 8,
    parameter int RGB_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [RGB_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [RGB_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [RGB_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            if (we) mem[waddr] <= wdata;
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/pp_cursor_unit.sv
module pp_cursor_unit #(
    parameter int COORD_W = 12,
    parameter int CUR_DIM = 64,
    parameter int RGB_W   = 24,
    parameter int CP_N    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pat_we,
    input  logic [$clog2(CUR_DIM*CUR_DIM/8)-1:0] pat_waddr,
    input  logic [15:0]        pat_wdata,
    input  logic               cp_we,
    input  logic [1:0]         cp_waddr,
    input  logic [RGB_W-1:0]   cp_wdata,
    input  logic [COORD_W-1:0] px,
    input  logic [COORD_W-1:0] py,
    input  logic [COORD_W-1:0] cx,
    input  logic [COORD_W-1:0] cy,
    input  logic               off,
    output logic [1:0]         code_q,
    output logic [RGB_W-1:0]   cp_rgb
);
    localparam int WORDS = CUR_DIM * CUR_DIM / 8;
    localparam int WA_W  = $clog2(WORDS);
    localparam int OFF_W = $clog2(CUR_DIM);
    localparam logic [COORD_W:0] DIM_V = (COORD_W+1)'(CUR_DIM);

    logic [15:0]      pattern [WORDS];
    logic [RGB_W-1:0] cpal [CP_N];

    logic [COORD_W:0] dxw, dyw;
    logic             hit;
    logic [WA_W-1:0]  word_sel;
    logic [15:0]      word_val;
    logic [1:0]       code_now;

    always_comb begin
        dxw      = {1'b0, px} - {1'b0, cx};
        dyw      = {1'b0, py} - {1'b0, cy};
        hit      = !off && !dxw[COORD_W] && (dxw < DIM_V)
                        && !dyw[COORD_W] && (dyw < DIM_V);
        word_sel = {dyw[OFF_W-1:0], dxw[OFF_W-1:3]};
        word_val = pattern[word_sel];
        code_now = hit ? word_val[{dxw[2:0], 1'b0} +: 2] : 2'd0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) pattern[i] <= '0;
            for (int i = 0; i < CP_N; i++) cpal[i] <= '0;
            code_q <= '0;
        end else begin
            if (pat_we) pattern[pat_waddr] <= pat_wdata;
            if (cp_we && 32'(cp_waddr) < CP_N) cpal[cp_waddr] <= cp_wdata;
            code_q <= code_now;
        end
    end

    always_comb begin
        cp_rgb = '0;
        for (int i = 0; i < CP_N; i++)
            if (32'(code_q) == i + 1) cp_rgb = cpal[i];
    end

    // R7
    cur_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> code_q == 2'd0);
endmodule

// File: rtl/pp_pixel_pipe.sv
module pp_pixel_pipe
    import pp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    input  logic [IDX_W-1:0]   pix_idx,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic               cur_off,
    input  logic               force_blank,
    input  logic               wr_en,
    input  logic [1:0]         wr_target,
    input  logic [8:0]         wr_addr,
    input  logic [RGB_W-1:0]   wr_data,
    output logic               out_valid,
    output logic [RGB_W-1:0]   out_rgb
);
    wr_target_e tgt;
    logic       pal_we, cp_we, pat_we;

    always_comb begin
        tgt    = wr_target_e'(wr_target);
        pal_we = wr_en && (tgt == WT_PALETTE);
        cp_we  = wr_en && (tgt == WT_CURPAL);
        pat_we = wr_en && (tgt == WT_PATTERN);
    end

    // LOOKUP stage outputs
    logic [RGB_W-1:0] pal_q;
    logic [1:0]       s1_code;
    logic [RGB_W-1:0] cp_rgb;
    logic             s1_valid, s1_blank;

    pp_palette_ram #(.IDX_W(IDX_W), .RGB_W(RGB_W)) u_pal (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pal_we),
        .waddr (wr_addr[IDX_W-1:0]),
        .wdata (wr_data),
        .raddr (pix_idx),
        .rdata (pal_q)
    );

    pp_cursor_unit #(.COORD_W(COORD_W), .CUR_DIM(CUR_DIM),
                     .RGB_W(RGB_W), .CP_N(CP_N)) u_cur (
        .clk       (clk),
        .rst_n     (rst_n),
        .pat_we    (pat_we),
        .pat_waddr (wr_addr),
        .pat_wdata (wr_data[15:0]),
        .cp_we     (cp_we),
        .cp_waddr  (wr_addr[1:0]),
        .cp_wdata  (wr_data),
        .px        (pix_x),
        .py        (pix_y),
        .cx        (cur_x),
        .cy        (cur_y),
        .off       (cur_off),
        .code_q    (s1_code),
        .cp_rgb    (cp_rgb)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_blank <= 1'b0;
        end else begin
            s1_valid <= pix_valid;
            s1_blank <= force_blank;
        end
    end

    // MERGE stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_blank)            out_rgb <= '0;
            else if (s1_code == 2'd0) out_rgb <= pal_q;
            else                      out_rgb <= cp_rgb;
        end
    end

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> ##1 out_valid);
    // R1
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> ##1 !out_valid);
    // R8
    blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_blank |=> out_rgb == '0);
    // R6
    transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s1_blank && s1_code == 2'd0) |=> out_rgb == $past(pal_q));
    // R6
    curcolor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s1_blank && s1_code != 2'd0) |=> out_rgb == $past(cp_rgb));
endmodule

// File: tb/pp_pixel_pipe_tb.sv
module pp_pixel_pipe_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_idx = '0;
    logic [11:0] pix_x = '0, pix_y = '0;
    logic [11:0] cur_x = 12'd100, cur_y = 12'd50;
    logic        cur_off = 1'b0, force_blank = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_target = '0;
    logic [8:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pp_pixel_pipe u_dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_idx(pix_idx),
        .pix_x(pix_x), .pix_y(pix_y), .cur_x(cur_x), .cur_y(cur_y),
        .cur_off(cur_off), .force_blank(force_blank), .wr_en(wr_en),
        .wr_target(wr_target), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    localparam logic [23:0] CP0 = 24'h111111, CP1 = 24'h222222, CP2 = 24'h333333;

    function automatic logic [23:0] pal_f(input logic [7:0] i);
        return {i, ~i, i ^ 8'h5A};
    endfunction

    // fields: idx[36:29] x[28:17] y[16:5] off[4] blank[3] kind[2:0]
    // kind: 0 palette, 1..3 cursor colour 0..2, 4 black
    localparam int NV = 14;
    localparam logic [36:0] VEC [NV] = '{
        {8'd7,   12'd10,  12'd10,  1'b0, 1'b0, 3'd0},  // R2 outside
        {8'd9,   12'd100, 12'd50,  1'b0, 1'b0, 3'd0},  // R6 code 0 at corner
        {8'd9,   12'd101, 12'd50,  1'b0, 1'b0, 3'd1},  // R5 bits 3:2
        {8'd9,   12'd102, 12'd50,  1'b0, 1'b0, 3'd2},  // R5 bits 5:4
        {8'd9,   12'd103, 12'd50,  1'b0, 1'b0, 3'd3},  // R5 bits 7:6
        {8'd30,  12'd163, 12'd113, 1'b0, 1'b0, 3'd1},  // R4 last col/row
        {8'd30,  12'd164, 12'd113, 1'b0, 1'b0, 3'd0},  // R4 right of window
        {8'd30,  12'd163, 12'd114, 1'b0, 1'b0, 3'd0},  // R4 below window
        {8'd31,  12'd99,  12'd50,  1'b0, 1'b0, 3'd0},  // R4 left of window
        {8'd31,  12'd101, 12'd49,  1'b0, 1'b0, 3'd0},  // R4 above window
        {8'd40,  12'd118, 12'd55,  1'b0, 1'b0, 3'd3},  // R5 word 42
        {8'd40,  12'd117, 12'd55,  1'b0, 1'b0, 3'd0},  // R5 neighbour
        {8'd9,   12'd101, 12'd50,  1'b1, 1'b0, 3'd0},  // R7 cursor off
        {8'd255, 12'd101, 12'd50,  1'b0, 1'b1, 3'd4}   // R8 blank
    };

    task automatic check(input bit ok, input string req,
                         input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] t, input logic [8:0] a, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_target = t; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pix_check(input logic [7:0] idx, input logic [11:0] x,
                             input logic [11:0] y, input logic off,
                             input logic blank, input logic [23:0] exp,
                             input string req);
        @(negedge clk);
        pix_valid = 1'b1; pix_idx = idx; pix_x = x; pix_y = y;
        cur_off = off; force_blank = blank;
        @(negedge clk);
        pix_valid = 1'b0; cur_off = 1'b0; force_blank = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b1, {req, " valid"}, 24'(out_valid), 24'd1);
        check(out_rgb == exp, req, out_rgb, exp);
    endtask

    function automatic logic [23:0] expect_of(input logic [36:0] v);
        case (v[2:0])
            3'd0:    return pal_f(v[36:29]);
            3'd1:    return CP0;
            3'd2:    return CP1;
            3'd3:    return CP2;
            default: return 24'h0;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0, "R9 out_valid in reset", 24'(out_valid), 24'd0);
        check(out_rgb == 24'h0, "R9 out_rgb in reset", out_rgb, 24'h0);
        rst_n = 1'b1;
        // R9: tables cleared
        pix_check(8'd7, 12'd0, 12'd0, 1'b0, 1'b0, 24'h0, "R9 palette cleared");
        pix_check(8'd7, 12'd103, 12'd50, 1'b0, 1'b0, 24'h0, "R9 pattern cleared");

        // R3: load all stores
        for (int i = 0; i < 256; i++) wr(2'd0, 9'(i), pal_f(8'(i)));
        wr(2'd1, 9'd0, CP0);
        wr(2'd1, 9'd1, CP1);
        wr(2'd1, 9'd2, CP2);
        wr(2'd2, 9'd0,   24'h00E4E4);
        wr(2'd2, 9'd511, 24'h004000);
        wr(2'd2, 9'd42,  24'h000030);

        for (int k = 0; k < NV; k++)
            pix_check(VEC[k][36:29], VEC[k][28:17], VEC[k][16:5], VEC[k][4],
                      VEC[k][3], expect_of(VEC[k]), $sformatf("R2/R4-R8 vec%0d", k));

        // R1: back-to-back stream
        @(negedge clk); pix_valid = 1'b1; pix_idx = 8'd1; pix_x = 12'd0; pix_y = 12'd0;
        @(negedge clk); pix_idx = 8'd2;
        @(negedge clk); pix_idx = 8'd3;
        check(out_valid && out_rgb == pal_f(8'd1), "R1 stream 0", out_rgb, pal_f(8'd1));
        @(negedge clk); pix_valid = 1'b0;
        check(out_valid && out_rgb == pal_f(8'd2), "R1 stream 1", out_rgb, pal_f(8'd2));
        @(negedge clk);
        check(out_valid && out_rgb == pal_f(8'd3), "R1 stream 2", out_rgb, pal_f(8'd3));
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid drops", 24'(out_valid), 24'd0);

        // R10: same-clock write and read of entry 20
        @(negedge clk);
        pix_valid = 1'b1; pix_idx = 8'd20; pix_x = 12'd0; pix_y = 12'd0;
        wr_en = 1'b1; wr_target = 2'd0; wr_addr = 9'd20; wr_data = 24'hABCDEF;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        pix_valid = 1'b0;
        check(out_rgb == pal_f(8'd20), "R10 old entry", out_rgb, pal_f(8'd20));
        @(negedge clk);
        check(out_rgb == 24'hABCDEF, "R10 new entry", out_rgb, 24'hABCDEF);

        // R11: ignored writes
        wr(2'd1, 9'd3, 24'hDEAD01);
        wr(2'd3, 9'd1, 24'hDEAD02);
        wr(2'd3, 9'd0, 24'hDEAD03);
        pix_check(8'd1, 12'd0, 12'd0, 1'b0, 1'b0, pal_f(8'd1), "R11 palette kept");
        pix_check(8'd1, 12'd101, 12'd50, 1'b0, 1'b0, CP0, "R11 cursor colour 0 kept");
        pix_check(8'd1, 12'd103, 12'd50, 1'b0, 1'b0, CP2, "R11 cursor colour 2 kept");

        // R9: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        pix_check(8'd1, 12'd0, 12'd0, 1'b0, 1'b0, 24'h0, "R9 palette re-cleared");
        pix_check(8'd1, 12'd101, 12'd50, 1'b0, 1'b0, 24'h0, "R9 cursor re-cleared");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 24'd0, 24'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule